// File: doc/BRIEF.md
# Macro Engine Arithmetic and Bitfield Unit

This unit is the datapath of a small command-processing macro engine. Each cycle the sequencer hands it one 32-bit instruction word, the raw contents of the two registers the instruction names (operand A and operand B) and the current carry flag. The unit decodes the operation, forms a 32-bit result and the carry flag to be written back, and flags any encoding it does not define. The register file, branching, the argument queue and method dispatch stay in the sequencer.

The unit covers register-register arithmetic with carry and borrow, five logic functions, add-immediate, three bitfield forms (replace, extract with an immediate position, extract with a position from A) and a read of an external state register. For the read, the unit drives the address A plus the immediate onto a combinational read port and passes the returned word through as the result. The whole path is combinational: the carry flag lives in the sequencer and loops back through this block.

Top module: `macalu_core`

## Requirements
- R1: Instruction bits [2:0] pick the operation: 0 register-register, 1 add immediate, 2 bitfield replace, 3 extract with immediate position, 4 extract with register position, 5 state read; 6 is undefined (illegal flag set, result 0); 7 is a branch slot that gives result 0, no illegal flag and carry out equal to carry in.
- R2: Operand A is selected by bits [13:11] and operand B by bits [16:14]; an index of 0 makes that operand read as zero whatever its input carries.
- R3: With op 0, function bits [21:17] = 0 (add) or 1 (add with carry) give the low 32 bits of A + B (+ carry in for function 1) and set carry out exactly when the unsigned sum exceeds 0xFFFFFFFF.
- R4: With op 0, function 2 (subtract) gives A − B and function 3 (subtract with borrow) gives A − B − 1 when carry in is 0 or A − B when it is 1; carry out is 1 exactly when no borrow occurs.
- R5: With op 0, functions 8 XOR, 9 OR, 10 AND, 11 A AND NOT B and 12 NOT (A AND B) give the bitwise result and leave carry out equal to carry in.
- R6: Op 1 gives A plus the immediate, which is bits [31:14] sign-extended to 32 bits; carry out equals carry in.
- R7: Op 2 takes (B >> src) & mask, with src bits [21:17], size bits [26:22] and mask = 2^size − 1, and writes it into A at position dst (bits [31:27]), clearing that field of A first; carry is unchanged.
- R8: Op 3 gives ((B >> A[4:0]) & mask) << dst, all shifts logical; carry is unchanged.
- R9: Op 4 gives ((B >> src) & mask) << A[4:0], only the low five bits of A counting; carry is unchanged.
- R10: Op 5 raises the read strobe, drives A plus the immediate on the read address and returns the read data as the result; for every other op the read strobe is low.
- R11: Op 0 with a function outside {0,1,2,3,8,9,10,11,12} raises the illegal flag, forces the result to zero and keeps carry out equal to carry in.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| instr | input | 32 | Instruction word under execution |
| opa_val | input | 32 | Raw contents of the register named by the A index |
| opb_val | input | 32 | Raw contents of the register named by the B index |
| carry_in | input | 1 | Current carry flag |
| st_rd_data | input | 32 | Data returned by the state-register read port |
| st_rd_en | output | 1 | State-register read strobe |
| st_rd_addr | output | 32 | State-register read address (A plus immediate) |
| result | output | 32 | Operation result |
| carry_out | output | 1 | Next carry flag |
| illegal | output | 1 | Undefined operation or function |

## Verification
The carry chain consumes the incoming flag and produces the next one in the same evaluation, and the zero-index rule substitutes an operand at the same moment the arithmetic and the bitfield shifters use it. The bench provokes both together by feeding add-with-carry and subtract-with-borrow at the 32-bit wrap point with an index of 0 on one side and a non-zero register value on the input, and by driving register-position shifts whose A input carries bits above bit 4. Each case is judged against a bench model that rebuilds the result, carry, illegal flag and read-port values from the instruction fields alone.

// File: rtl/macalu_pkg.sv
`timescale 1ns/1ps
package macalu_pkg;
  localparam int WORD_W  = 32;
  localparam int SH_W    = $clog2(WORD_W);
  localparam int IMM_LSB = 14;
  localparam int IMM_W   = WORD_W - IMM_LSB;
  localparam int IDX_W   = 3;

  typedef enum logic [2:0] {
    OP_REGREG = 3'd0,
    OP_ADDI   = 3'd1,
    OP_BFINS  = 3'd2,
    OP_BFXIMM = 3'd3,
    OP_BFXREG = 3'd4,
    OP_STREAD = 3'd5,
    OP_RSVD   = 3'd6,
    OP_BRANCH = 3'd7
  } op_e;

  typedef enum logic [4:0] {
    FN_ADD  = 5'd0,
    FN_ADC  = 5'd1,
    FN_SUB  = 5'd2,
    FN_SBB  = 5'd3,
    FN_XOR  = 5'd8,
    FN_OR   = 5'd9,
    FN_AND  = 5'd10,
    FN_ANDN = 5'd11,
    FN_NAND = 5'd12
  } fn_e;

  typedef struct packed {
    op_e                op;
    logic [4:0]         fn;
    logic [SH_W-1:0]    src_bit;
    logic [SH_W-1:0]    fld_size;
    logic [SH_W-1:0]    dst_bit;
    logic [WORD_W-1:0]  imm;
  } dec_t;
endpackage

// File: rtl/macalu_decode.sv
`timescale 1ns/1ps
module macalu_decode
  import macalu_pkg::*;
#(
  parameter int W = WORD_W
) (
  input  logic [31:0]  instr,
  input  logic [W-1:0] opa_raw,
  input  logic [W-1:0] opb_raw,
  output dec_t         dec,
  output logic [W-1:0] opa,
  output logic [W-1:0] opb
);
  localparam int A_LSB = 11;
  localparam int B_LSB = 14;

  logic [IDX_W-1:0] a_idx;
  logic [IDX_W-1:0] b_idx;
  logic             unused_bits;

  assign a_idx = instr[A_LSB +: IDX_W];
  assign b_idx = instr[B_LSB +: IDX_W];
  assign unused_bits = ^instr[10:3];

  always_comb begin
    dec.op       = op_e'(instr[2:0]);
    dec.fn       = instr[21:17];
    dec.src_bit  = instr[21:17];
    dec.fld_size = instr[26:22];
    dec.dst_bit  = instr[31:27];
    dec.imm      = {{(W-IMM_W){instr[31]}}, instr[31:IMM_LSB]};
  end

  assign opa = (a_idx == '0) ? '0 : opa_raw;
  assign opb = (b_idx == '0) ? '0 : opb_raw;
endmodule

// File: rtl/macalu_regop.sv
`timescale 1ns/1ps
module macalu_regop
  import macalu_pkg::*;
#(
  parameter int W = WORD_W
) (
  input  logic [4:0]   fn,
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic         cin,
  output logic [W-1:0] res,
  output logic         cout,
  output logic         bad
);
  logic [W:0] a_ext;
  logic [W:0] b_ext;
  logic [W:0] wide;

  assign a_ext = {1'b0, a};
  assign b_ext = {1'b0, b};

  always_comb begin
    wide = '0;
    res  = '0;
    cout = cin;
    bad  = 1'b0;
    case (fn)
      FN_ADD: begin
        wide = a_ext + b_ext;
        res  = wide[W-1:0];
        cout = wide[W];
      end
      FN_ADC: begin
        wide = a_ext + b_ext + {{W{1'b0}}, cin};
        res  = wide[W-1:0];
        cout = wide[W];
      end
      FN_SUB: begin
        wide = a_ext - b_ext;
        res  = wide[W-1:0];
        cout = ~wide[W];
      end
      FN_SBB: begin
        wide = a_ext - b_ext - {{W{1'b0}}, ~cin};
        res  = wide[W-1:0];
        cout = ~wide[W];
      end
      FN_XOR:  res = a ^ b;
      FN_OR:   res = a | b;
      FN_AND:  res = a & b;
      FN_ANDN: res = a & ~b;
      FN_NAND: res = ~(a & b);
      default: bad = 1'b1;
    endcase
  end
endmodule

// File: rtl/macalu_bitfield.sv
`timescale 1ns/1ps
module macalu_bitfield
  import macalu_pkg::*;
#(
  parameter int W = WORD_W
) (
  input  op_e             op,
  input  logic [W-1:0]    a,
  input  logic [W-1:0]    b,
  input  logic [SH_W-1:0] src_bit,
  input  logic [SH_W-1:0] fld_size,
  input  logic [SH_W-1:0] dst_bit,
  output logic [W-1:0]    res
);
  logic [W-1:0]    mask;
  logic [SH_W-1:0] a_sh;
  logic [W-1:0]    fld_src;
  logic [W-1:0]    fld_var;
  logic [W-1:0]    ins_val;
  logic [W-1:0]    xim_val;
  logic [W-1:0]    xrg_val;
  logic            unused_a;

  assign a_sh     = a[SH_W-1:0];
  assign unused_a = ^a[W-1:SH_W];

  // mask = 2^size - 1, built bit by bit
  for (genvar i = 0; i < W; i++) begin : g_mask
    assign mask[i] = (i < int'(fld_size));
  end

  assign fld_src = (b >> src_bit) & mask;
  assign fld_var = (b >> a_sh) & mask;
  assign ins_val = (a & ~(mask << dst_bit)) | (fld_src << dst_bit);
  assign xim_val = fld_var << dst_bit;
  assign xrg_val = fld_src << a_sh;

  always_comb begin
    case (op)
      OP_BFINS:  res = ins_val;
      OP_BFXIMM: res = xim_val;
      OP_BFXREG: res = xrg_val;
      default:   res = '0;
    endcase
  end
endmodule

// File: rtl/macalu_core.sv
`timescale 1ns/1ps
module macalu_core
  import macalu_pkg::*;
#(
  parameter int W = WORD_W
) (
  input  logic [31:0]  instr,
  input  logic [W-1:0] opa_val,
  input  logic [W-1:0] opb_val,
  input  logic         carry_in,
  input  logic [W-1:0] st_rd_data,
  output logic         st_rd_en,
  output logic [W-1:0] st_rd_addr,
  output logic [W-1:0] result,
  output logic         carry_out,
  output logic         illegal
);
  dec_t         dec;
  logic [W-1:0] opa;
  logic [W-1:0] opb;
  logic [W-1:0] rr_res;
  logic         rr_cout;
  logic         rr_bad;
  logic [W-1:0] bf_res;
  logic [W-1:0] a_plus_imm;

  macalu_decode #(.W(W)) u_dec (
    .instr   (instr),
    .opa_raw (opa_val),
    .opb_raw (opb_val),
    .dec     (dec),
    .opa     (opa),
    .opb     (opb)
  );

  macalu_regop #(.W(W)) u_rr (
    .fn   (dec.fn),
    .a    (opa),
    .b    (opb),
    .cin  (carry_in),
    .res  (rr_res),
    .cout (rr_cout),
    .bad  (rr_bad)
  );

  macalu_bitfield #(.W(W)) u_bf (
    .op       (dec.op),
    .a        (opa),
    .b        (opb),
    .src_bit  (dec.src_bit),
    .fld_size (dec.fld_size),
    .dst_bit  (dec.dst_bit),
    .res      (bf_res)
  );

  // shared adder for add-immediate and the state-read address
  assign a_plus_imm = opa + dec.imm;
  assign st_rd_addr = a_plus_imm;

  always_comb begin
    result    = '0;
    carry_out = carry_in;
    illegal   = 1'b0;
    st_rd_en  = 1'b0;
    case (dec.op)
      OP_REGREG: begin
        illegal = rr_bad;
        if (!rr_bad) begin
          result    = rr_res;
          carry_out = rr_cout;
        end
      end
      OP_ADDI:   result = a_plus_imm;
      OP_BFINS,
      OP_BFXIMM,
      OP_BFXREG: result = bf_res;
      OP_STREAD: begin
        st_rd_en = 1'b1;
        result   = st_rd_data;
      end
      OP_RSVD:   illegal = 1'b1;
      default:   result = '0;
    endcase
  end
endmodule

// File: rtl/macalu_core_chk.sv
`timescale 1ns/1ps
module macalu_core_chk #(
  parameter int W = 32
) (
  input logic [31:0]  instr,
  input logic [W-1:0] opa_val,
  input logic [W-1:0] opb_val,
  input logic         carry_in,
  input logic [W-1:0] st_rd_data,
  input logic         st_rd_en,
  input logic [W-1:0] st_rd_addr,
  input logic [W-1:0] result,
  input logic         carry_out,
  input logic         illegal
);
  logic [W-1:0] ea;
  logic [W-1:0] eb;
  logic         is_rr;
  logic         unused_chk;

  assign ea    = (instr[13:11] == 3'd0) ? '0 : opa_val;
  assign eb    = (instr[16:14] == 3'd0) ? '0 : opb_val;
  assign is_rr = (instr[2:0] == 3'd0);
  assign unused_chk = ^st_rd_addr;

  always_comb begin
    // R11: an undefined encoding yields zero and leaves carry alone
    a_r11_illegal_quiet: assert (!illegal || (result == '0 && carry_out == carry_in));
    // R1: branch slot is silent
    a_r1_branch_silent: assert (instr[2:0] != 3'd7 ||
      (result == '0 && !illegal && !st_rd_en && carry_out == carry_in));
    // R3: plain add carries exactly on wrap
    a_r3_add_wrap: assert (!(is_rr && instr[21:17] == 5'd0) || carry_out == (result < ea));
    // R4: subtract carry means no borrow
    a_r4_sub_noborrow: assert (!(is_rr && instr[21:17] == 5'd2) || carry_out == (ea >= eb));
    // R5: logic functions keep carry
    a_r5_logic_carry: assert (!(is_rr && instr[21:17] >= 5'd8 && instr[21:17] <= 5'd12) ||
      carry_out == carry_in);
    // R10: read strobe returns the port data
    a_r10_read_pass: assert (!st_rd_en || (result == st_rd_data && !illegal && instr[2:0] == 3'd5));
  end
endmodule

bind macalu_core macalu_core_chk #(.W(W)) u_chk (
  .instr      (instr),
  .opa_val    (opa_val),
  .opb_val    (opb_val),
  .carry_in   (carry_in),
  .st_rd_data (st_rd_data),
  .st_rd_en   (st_rd_en),
  .st_rd_addr (st_rd_addr),
  .result     (result),
  .carry_out  (carry_out),
  .illegal    (illegal)
);

// File: tb/sim_macalu_core.sv
`timescale 1ns/1ps
module sim_macalu_core;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] instr = '0, opa_val = '0, opb_val = '0, st_rd_data = '0;
  logic        carry_in = 1'b0;
  logic        st_rd_en, carry_out, illegal;
  logic [31:0] st_rd_addr, result;
  int          errors = 0;
  int          checks = 0;
  bit          done = 1'b0;

  always #2.5 clk = ~clk;

  macalu_core u0 (
    .instr(instr), .opa_val(opa_val), .opb_val(opb_val), .carry_in(carry_in),
    .st_rd_data(st_rd_data), .st_rd_en(st_rd_en), .st_rd_addr(st_rd_addr),
    .result(result), .carry_out(carry_out), .illegal(illegal)
  );

  function automatic void model(input logic [31:0] ins, ar, br, input logic cin,
                                input logic [31:0] rdd, output logic [31:0] r,
                                output logic c, output logic ill, output logic re,
                                output logic [31:0] ra);
    logic [31:0] a, b, imm, m, f;
    longint unsigned s;
    int sz;
    a = (ins[13:11] == 0) ? 32'd0 : ar;
    b = (ins[16:14] == 0) ? 32'd0 : br;
    imm = 32'($signed(ins) >>> 14);
    sz = int'(ins[26:22]);
    m = 0;
    for (int i = 0; i < sz; i++) m[i] = 1'b1;
    r = 0; c = cin; ill = 0; re = 0; ra = a + imm;
    case (ins[2:0])
      3'd0: case (ins[21:17])
        5'd0: begin s = longint'(a) + longint'(b); r = s[31:0]; c = s > 64'hFFFFFFFF; end
        5'd1: begin s = longint'(a) + longint'(b) + (cin ? 1 : 0); r = s[31:0]; c = s > 64'hFFFFFFFF; end
        5'd2: begin r = a - b; c = (a >= b); end
        5'd3: begin r = a - b - (cin ? 0 : 1);
                    c = longint'(a) >= longint'(b) + (cin ? 0 : 1); end
        5'd8:  r = a ^ b;
        5'd9:  r = a | b;
        5'd10: r = a & b;
        5'd11: r = a & ~b;
        5'd12: r = ~(a & b);
        default: ill = 1;
      endcase
      3'd1: r = a + imm;
      3'd2: begin f = (b >> ins[21:17]) & m;
                  r = (a & ~(m << ins[31:27])) | (f << ins[31:27]); end
      3'd3: r = ((b >> a[4:0]) & m) << ins[31:27];
      3'd4: r = ((b >> ins[21:17]) & m) << a[4:0];
      3'd5: begin re = 1; r = rdd; end
      3'd6: ill = 1;
      default: r = 0;
    endcase
  endfunction

  function automatic string tag_of(input logic [31:0] ins);
    case (ins[2:0])
      3'd0: if (ins[21:17] <= 1) return "R3";
            else if (ins[21:17] <= 3) return "R4";
            else if (ins[21:17] >= 8 && ins[21:17] <= 12) return "R5";
            else return "R11";
      3'd1: return "R6";
      3'd2: return "R7";
      3'd3: return "R8";
      3'd4: return "R9";
      3'd5: return "R10";
      default: return "R1";
    endcase
  endfunction

  task automatic apply(input logic [31:0] ins, ar, br, input logic cin,
                       input logic [31:0] rdd, input string req);
    logic [31:0] er, ea; logic ec, ei, ee;
    @(negedge clk);
    instr = ins; opa_val = ar; opb_val = br; carry_in = cin; st_rd_data = rdd;
    #1;
    model(ins, ar, br, cin, rdd, er, ec, ei, ee, ea);
    checks++;
    if (result !== er || carry_out !== ec || illegal !== ei || st_rd_en !== ee ||
        (ee && st_rd_addr !== ea)) begin
      errors++;
      $display("FAIL %s instr=%h: got res=%h c=%b ill=%b re=%b ra=%h, exp res=%h c=%b ill=%b re=%b ra=%h",
               req, ins, result, carry_out, illegal, st_rd_en, st_rd_addr, er, ec, ei, ee, ea);
    end
  endtask

  function automatic logic [31:0] rr(input logic [4:0] fn, input logic [2:0] bi, ai);
    return {10'd0, fn, bi, ai, 8'd0, 3'd0};
  endfunction
  function automatic logic [31:0] bf(input logic [2:0] op, input logic [4:0] dst, sz, src,
                                     input logic [2:0] bi, ai);
    return {dst, sz, src, bi, ai, 8'd0, op};
  endfunction
  function automatic logic [31:0] im(input logic [2:0] op, input logic [17:0] v, input logic [2:0] ai);
    return {v, ai, 8'd0, op};
  endfunction

  initial begin
    int unsigned seed;
    logic [31:0] ins;
    seed = 32'h5EED_1234;
    void'($urandom(seed));
    repeat (3) @(posedge clk);
    rst_n = 1'b1;
    apply(32'd0, 32'd0, 32'd0, 1'b0, 32'd0, "R1 reset state");
    // R3 wrap with and without incoming carry
    apply(rr(5'd0, 3'd2, 3'd1), 32'hFFFF_FFFF, 32'd1, 1'b0, 0, "R3 add wrap");
    apply(rr(5'd1, 3'd0, 3'd1), 32'hFFFF_FFFF, 32'h55, 1'b1, 0, "R3 adc cin with B idx0 (R2)");
    apply(rr(5'd1, 3'd2, 3'd1), 32'h7FFF_FFFF, 32'h8000_0000, 1'b0, 0, "R3 adc no wrap");
    // R4 borrow edges
    apply(rr(5'd2, 3'd2, 3'd1), 32'd5, 32'd5, 1'b0, 0, "R4 sub equal");
    apply(rr(5'd3, 3'd2, 3'd1), 32'd5, 32'd5, 1'b0, 0, "R4 sbb borrow");
    apply(rr(5'd3, 3'd2, 3'd0), 32'd9, 32'd0, 1'b1, 0, "R4 sbb A idx0 (R2)");
    apply(rr(5'd2, 3'd3, 3'd4), 32'd3, 32'd4, 1'b1, 0, "R4 sub underflow");
    // R2 index zero ignores the input
    apply(rr(5'd9, 3'd5, 3'd0), 32'hDEAD_BEEF, 32'h1234, 1'b0, 0, "R2 A idx0");
    // R5 logic keeps carry
    apply(rr(5'd12, 3'd2, 3'd1), 32'hF0F0, 32'hFF00, 1'b1, 0, "R5 nand");
    apply(rr(5'd11, 3'd2, 3'd1), 32'hF0F0, 32'hFF00, 1'b0, 0, "R5 andnot");
    // R6 negative immediate
    apply(im(3'd1, 18'h3FFFD, 3'd1), 32'd10, 0, 1'b1, 0, "R6 addi neg");
    // R7 / R8 / R9
    apply(bf(3'd2, 5'd16, 5'd8, 5'd4, 3'd2, 3'd1), 32'hFFFF_FFFF, 32'hABCD, 1'b1, 0, "R7 replace");
    apply(bf(3'd3, 5'd28, 5'd4, 5'd0, 3'd2, 3'd1), 32'd8, 32'hABCD, 1'b0, 0, "R8 extract imm pos");
    apply(bf(3'd4, 5'd0, 5'd4, 5'd0, 3'd2, 3'd1), 32'h24, 32'hABCD, 1'b0, 0, "R9 extract reg pos high bits");
    apply(bf(3'd4, 5'd0, 5'd0, 5'd0, 3'd2, 3'd1), 32'd3, 32'hFFFF, 1'b1, 0, "R9 size zero");
    // R10 read
    apply(im(3'd5, 18'd4, 3'd1), 32'h100, 0, 1'b0, 32'hCAFE_F00D, "R10 state read");
    // R11 / R1 undefined and branch
    apply(rr(5'd4, 3'd2, 3'd1), 32'd7, 32'd1, 1'b1, 0, "R11 undefined fn");
    apply(rr(5'd31, 3'd2, 3'd1), 32'd7, 32'd1, 1'b0, 0, "R11 undefined fn 31");
    apply(32'h1234_5676, 32'd7, 32'd1, 1'b1, 0, "R1 op6 illegal");
    apply(32'hFFFF_FFFF, 32'd7, 32'd1, 1'b1, 32'h99, "R1 branch slot");
    // random mix
    for (int n = 0; n < 3000; n++) begin
      ins = $urandom;
      if (n % 2 == 0) ins[21:17] = 5'($urandom_range(0, 12));
      apply(ins, (n % 7 == 0) ? 32'hFFFF_FFFF : $urandom, $urandom, 1'($urandom),
            $urandom, tag_of(ins));
    end
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: got timeout, exp completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule